// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block turns single memory requests from a small 8-bit processor core into external bus cycles on a 13-bit address space. The low address byte and the data byte take turns on one shared 8-bit bus. The five upper address bits have lines of their own. Each bus cycle is five clock periods long, and one clock period stands for one oscillator period.

In the first phase the sequencer sends the low address byte out on the shared bus under a high address-strobe pulse. It holds that byte for one more phase after the strobe falls. It then turns the bus around for data under a separate data strobe. On a read the bus is released and the incoming byte is captured on the clock edge that ends the data strobe. On a write the data byte is driven from the rise of the data strobe until one phase after it falls. A read/write line and an opcode-fetch indicator cover the whole cycle.

The core sees a ready/valid handshake on the request side. It gets a one-clock done pulse that carries the captured read byte. A new request can be accepted in the final phase of a cycle, so cycles can run back to back.

Top module: `mux_bus_seq`

## Requirements
- R1: After reset the outputs are in the idle state: `as`, `ds`, `bus_oe`, `fetch_ind` and `done` are low, and `rw` and `req_ready` are high.
- R2: An accepted request runs phases 0 to 4, one clock each. `done` is high only in phase 4, which is the fifth clock after the accepting edge. Back-to-back requests complete one every five clocks.
- R3: `as` is high only in phase 0 and `ds` is high only in phases 2 and 3. The two strobes are never high at the same time, and `ds` rises on the clock after `as` falls.
- R4: During phases 0 and 1, `bus_oe` is high and `bus_ad_out` carries address bits 7:0. Throughout the cycle, `addr_hi` carries address bits 12:8.
- R5: `rw` is 0 for a write and 1 for a read, and it is stable for the whole cycle. `rw` is 1 when idle.
- R6: On a read, `bus_oe` is low in phases 2 to 4. `bus_ad_in` is captured at the clock edge that ends phase 3, and it is presented on `rdata` while `done` is high.
- R7: On a write, `bus_oe` is high and `bus_ad_out` carries the write byte in phases 2, 3 and 4. The byte is therefore still held one phase after `ds` falls.
- R8: `fetch_ind` is high for all five phases of a request whose `req_fetch` is 1. It stays low for the whole cycle if `irq_service` was 1 when the request was accepted.
- R9: `req_ready` is high only when idle or in phase 4. A `req_valid` in phases 0 to 3 is ignored: the running cycle keeps its address and the next cycle starts only after phase 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-rate clock, one phase per period |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Core presents a request |
| req_ready | output | 1 | Sequencer can accept a request this clock |
| req_addr | input | 13 | Byte address |
| req_wdata | input | 8 | Write byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | Request is an opcode fetch |
| irq_service | input | 1 | Core is servicing an interrupt (suppresses fetch indicator) |
| done | output | 1 | One-clock pulse in the last phase |
| rdata | output | 8 | Captured read byte, valid with done on reads |
| bus_ad_out | output | 8 | Shared bus, driven value |
| bus_ad_in | input | 8 | Shared bus, sampled value |
| bus_oe | output | 1 | Shared bus output enable |
| addr_hi | output | 5 | Upper address lines |
| as | output | 1 | Address strobe, active high |
| ds | output | 1 | Data strobe, active high |
| rw | output | 1 | 1 = read, 0 = write |
| fetch_ind | output | 1 | Opcode-fetch indicator |

## Verification
The embedded assertions check the local rules on every clock:
- the two strobes never overlap, and `ds` follows the fall of `as`;
- the low address is held across the fall of `as`;
- `rw` does not change inside a cycle;
- the bus is released whenever a read strobe is up;
- `done` comes right after the data strobe ends;
- the request port is closed while `as` is high.

Only the bench's scenarios can show the values that end up on the bus and in `rdata`, using a memory model:
- write bytes land at the decoded 13-bit address, and reads return them;
- the fetch indicator is suppressed during interrupt service;
- an early request is deferred, and back-to-back cycles keep the five-clock spacing.

// File: rtl/mux_bus_seq.sv
module mux_bus_seq #(
  parameter int AW  = 13,
  parameter int DW  = 8,
  parameter int NPH = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_write,
  input  logic          req_fetch,
  input  logic          irq_service,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] bus_ad_out,
  input  logic [DW-1:0] bus_ad_in,
  output logic          bus_oe,
  output logic [AW-DW-1:0] addr_hi,
  output logic          as,
  output logic          ds,
  output logic          rw,
  output logic          fetch_ind
);
  localparam int PW = $clog2(NPH);
  localparam logic [PW-1:0] PH_LAST = PW'(NPH - 1);
  localparam logic [PW-1:0] PH_DS0  = PW'(2);
  localparam logic [PW-1:0] PH_DS1  = PW'(NPH - 2);

  logic          busy;
  logic [PW-1:0] ph;
  logic [AW-1:0] a_q;
  logic [DW-1:0] w_q, r_q;
  logic          wr_q, fe_q;

  wire last    = busy && (ph == PH_LAST);
  wire addr_ph = ph < PH_DS0;
  wire take    = req_valid && req_ready;

  assign req_ready = !busy || last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ph   <= '0;
      a_q  <= '0;
      w_q  <= '0;
      r_q  <= '0;
      wr_q <= 1'b0;
      fe_q <= 1'b0;
    end else begin
      if (take) begin
        busy <= 1'b1;
        ph   <= '0;
        a_q  <= req_addr;
        w_q  <= req_wdata;
        wr_q <= req_write;
        fe_q <= req_fetch && !irq_service;
      end else if (last) begin
        busy <= 1'b0;
      end else if (busy) begin
        ph <= ph + 1'b1;
      end
      if (busy && !wr_q && ph == PH_DS1) r_q <= bus_ad_in;
    end
  end

  assign as         = busy && (ph == '0);
  assign ds         = busy && (ph >= PH_DS0) && (ph <= PH_DS1);
  assign bus_oe     = busy && (addr_ph || wr_q);
  assign bus_ad_out = !busy ? '0 : (addr_ph ? a_q[DW-1:0] : w_q);
  assign addr_hi    = a_q[AW-1:DW];
  assign rw         = !(busy && wr_q);
  assign fetch_ind  = busy && fe_q;
  assign done       = last;
  assign rdata      = r_q;

  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(as && ds));
  assert_ds_after_as_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(as) |-> !ds ##1 $rose(ds));
  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(as) |-> $stable(bus_ad_out) && bus_oe);
  assert_rw_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ph != '0) |-> $stable(rw));
  assert_read_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ds && rw) |-> !bus_oe);
  assert_done_after_ds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $fell(ds));
  assert_fetch_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_ind) |-> as);
  assert_no_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    as |-> !req_ready);
endmodule

// File: tb/test_mux_bus_seq.sv
module test_mux_bus_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_fetch = 1'b0, irq_service = 1'b0;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, done, bus_oe, as, ds, rw, fetch_ind;
  logic [7:0] rdata, bus_ad_out, bus_ad_in;
  logic [4:0] addr_hi;

  int total = 0, bad = 0, cyc = 0;
  logic [7:0]  mem [0:8191];
  logic [7:0]  shadow [0:8191];
  logic [12:0] lat = '0;

  always #2.5 clk = ~clk;

  mux_bus_seq i_mux_bus_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
    .req_fetch(req_fetch), .irq_service(irq_service), .done(done), .rdata(rdata),
    .bus_ad_out(bus_ad_out), .bus_ad_in(bus_ad_in), .bus_oe(bus_oe),
    .addr_hi(addr_hi), .as(as), .ds(ds), .rw(rw), .fetch_ind(fetch_ind));

  always @(negedge as) lat = {addr_hi, bus_ad_out};
  always @(negedge ds) if (!rw && rst_n) mem[lat] = bus_ad_out;
  assign bus_ad_in = (ds && rw) ? mem[lat] : 8'h00;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic phase_chk(input int p, input logic [12:0] a, input logic [7:0] wd,
                           input bit wr, input bit fe, input bit irq, input logic [7:0] rexp);
    bit exp_oe = (p < 2) || wr;
    chk(as == (p == 0), "R3 as", as, p == 0);
    chk(ds == (p == 2 || p == 3), "R3 ds", ds, p == 2 || p == 3);
    chk(done == (p == 4), "R2 done", done, p == 4);
    chk(req_ready == (p == 4), "R9 ready", req_ready, p == 4);
    chk(rw == !wr, "R5 rw", rw, !wr);
    chk(addr_hi == a[12:8], "R4 addr_hi", addr_hi, a[12:8]);
    chk(fetch_ind == (fe && !irq), "R8 fetch_ind", fetch_ind, fe && !irq);
    if (p < 2) begin
      chk(bus_oe && bus_ad_out == a[7:0], "R4 addr lo", bus_ad_out, a[7:0]);
    end else if (wr) begin
      chk(bus_oe && bus_ad_out == wd, "R7 wdata", bus_ad_out, wd);
    end else begin
      chk(bus_oe == exp_oe, "R6 oe", bus_oe, exp_oe);
    end
    if (p == 4 && !wr) chk(rdata == rexp, "R6 rdata", rdata, rexp);
  endtask

  task automatic one_cycle(input logic [12:0] a, input logic [7:0] wd,
                           input bit wr, input bit fe, input bit irq);
    logic [7:0] rexp = shadow[a];
    @(negedge clk);
    req_addr = a; req_wdata = wd; req_write = wr; req_fetch = fe; irq_service = irq;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; irq_service = 1'b0;
    phase_chk(0, a, wd, wr, fe, irq, rexp);
    for (int p = 1; p < 5; p++) begin
      @(negedge clk);
      phase_chk(p, a, wd, wr, fe, irq, rexp);
    end
    if (wr) begin
      shadow[a] = wd;
      chk(mem[a] == wd, "R7 mem write", mem[a], wd);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8192; k++) begin
      mem[k] = 8'(k * 7 + 1);
      shadow[k] = 8'(k * 7 + 1);
    end
    repeat (3) @(negedge clk);
    chk(!as && !ds && !bus_oe && !fetch_ind && !done, "R1 idle strobes", {as, ds, bus_oe, fetch_ind, done}, 0);
    chk(rw && req_ready, "R1 rw/ready", {rw, req_ready}, 3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rw && req_ready && !as, "R1 after release", {rw, req_ready, as}, 6);

    for (int i = 0; i < 96; i++) begin
      logic [12:0] a = 13'((i * 677 + 3) % 8192);
      one_cycle(a, 8'(a[7:0] ^ a[12:5] ^ 8'(i)), 1'b1, (i % 3) == 0, (i % 5) == 0);
    end
    for (int i = 0; i < 96; i++) begin
      logic [12:0] a = 13'((i * 677 + 3) % 8192);
      one_cycle(a, 8'h00, 1'b0, (i % 2) == 0, (i % 7) == 0);
    end
    for (int i = 0; i < 16; i++) begin
      logic [12:0] a = 13'(i * 513 + 100);
      one_cycle(a, 8'h00, 1'b0, 1'b1, 1'b0);
    end

    // R9: request raised mid-cycle is deferred until phase 4
    @(negedge clk);
    req_addr = 13'h0155; req_write = 1'b0; req_fetch = 1'b0; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_addr = 13'h1AAA;
    @(negedge clk);
    chk(!req_ready && bus_ad_out == 8'h55, "R9 ignored mid-cycle", bus_ad_out, 8'h55);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    chk(done && req_ready, "R9 ready in phase 4", {done, req_ready}, 3);
    @(negedge clk);
    chk(as && bus_ad_out == 8'hAA && addr_hi == 5'h1A, "R9 next starts after phase 4", bus_ad_out, 8'hAA);
    req_valid = 1'b0;
    for (int n = 2; n <= 5; n++) @(negedge clk);
    chk(done, "R2 second done", done, 1);

    // R2: back-to-back spacing
    @(negedge clk);
    req_addr = 13'h0001; req_valid = 1'b1;
    @(posedge clk);
    for (int n = 1; n <= 10; n++) begin
      @(negedge clk);
      chk(done == (n == 5 || n == 10), "R2 back-to-back done", done, n == 5 || n == 10);
      chk(as == (n == 1 || n == 6), "R2 back-to-back as", as, n == 1 || n == 6);
      if (n == 6) req_valid = 1'b0;
    end
    @(negedge clk);
    chk(!as && req_ready && rw, "R2 idle after pair", {as, req_ready, rw}, 3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule